// File: doc/BRIEF.md
# Masked Mailbox Send Engine

This engine takes 64-bit send commands and turns each one into a 32-bit write into a target core's register space. It has two command offsets. A "mail" command writes one of eight mailbox words above a configurable base. An "any" command writes an arbitrary 16-bit register address that the command carries. In both cases the target core index comes from a ten-bit field of the command.

Four bits of the command select bytes of the target word to preserve. When at least one of them is set, the engine first reads the existing word through its memory master port. It then writes the existing bytes in the preserved lanes and the command's payload bytes in all other lanes. When none is set, no read is issued and the payload is written whole.

A command naming a core outside the configured range is answered with an error response and causes no memory traffic. The engine works on one command at a time: it holds `cmd_ready` low from acceptance until it returns to idle.

Top module: `mbx_send_engine`

## Requirements
- R1: Only a command with `cmd_size8`=1 whose 12-bit `cmd_offset` equals 0x048 (mail) or 0x158 (any) is processed; any other command is accepted, causes no memory access and no response, and leaves `cmd_ready` high.
- R2: The target core is `cmd_data[25:16]`; a value of NUM_CPU or more produces a one-cycle `resp_valid` with `resp_err`=1 and no memory access.
- R3: For a mail command the memory address is MBOX_BASE + 0x20 + (`cmd_data` AND 0x1C).
- R4: For an any command the memory address is `cmd_data[15:0]`.
- R5: With keep mask `cmd_data[30:27]` non-zero, a read of the target address comes first, then a write of the same address whose byte i is the old byte i when mask bit i is set, else byte i of `cmd_data[63:32]`.
- R6: With a zero keep mask no read is issued, and the write data is `cmd_data[63:32]` unchanged.
- R7: Every memory access carries the resolved target core on `mem_core`, which is always below NUM_CPU.
- R8: A processed command drops `cmd_ready` on the cycle after acceptance until the engine is idle again. `mem_req` with its address and direction holds until `mem_ack`. A successful command ends with a one-cycle `resp_valid` with `resp_err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_offset | input | 12 | Low 12 bits of the command address |
| cmd_size8 | input | 1 | Command is a full 8-byte write |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | A command is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Target register address |
| mem_core | output | CORE_W | Core on whose behalf the access is made |
| mem_wdata | output | 32 | Write data, little-endian word |
| mem_ack | input | 1 | Request taken |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| resp_valid | output | 1 | Command finished |
| resp_err | output | 1 | Finished with a decode error |

## Verification
The bench goes after keep masks of zero, all-ones and mixed lanes. A design that inverted the mask sense or always read first would show wrong write data or an extra read. Mail commands with stray low and high bits in the slot field catch a wrong address mask. Core IDs just past the range and at the field maximum catch a range test that is off by one or truncated. Wrong-size and wrong-offset commands would expose an engine that decoded too loosely, and a stalled memory acknowledge would expose a request dropped or changed before it was taken.

// File: rtl/mbx_send_pkg.sv
package mbx_send_pkg;

    localparam int CMD_W   = 64;
    localparam int WORD_W  = 32;
    localparam int TADDR_W = 16;
    localparam int OFF_W   = 12;
    localparam int ID_W    = 10;
    localparam int LANES   = WORD_W / 8;

    localparam logic [OFF_W-1:0] OFF_MAIL = 12'h048;
    localparam logic [OFF_W-1:0] OFF_ANY  = 12'h158;

    localparam int ID_LSB   = 16;
    localparam int KEEP_LSB = 27;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT_RD,
        ST_WRITE,
        ST_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        K_NONE,
        K_MAIL,
        K_ANY
    } cmd_kind_t;

    typedef struct packed {
        logic               act;
        logic               bad;
        logic [ID_W-1:0]    core;
        logic [TADDR_W-1:0] taddr;
        logic [LANES-1:0]   keep;
        logic [WORD_W-1:0]  payload;
    } job_t;

    function automatic cmd_kind_t classify(input logic [OFF_W-1:0] off, input logic size8);
        if (!size8)            return K_NONE;
        else if (off == OFF_MAIL) return K_MAIL;
        else if (off == OFF_ANY)  return K_ANY;
        else                   return K_NONE;
    endfunction

    function automatic logic [TADDR_W-1:0] slot_addr(input logic [TADDR_W-1:0] base,
                                                     input logic [2:0] slot);
        return base + 16'h0020 + {11'b0, slot, 2'b00};
    endfunction

endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
    import mbx_send_pkg::*;
#(
    parameter int                 NUM_CPU   = 4,
    parameter logic [TADDR_W-1:0] MBOX_BASE = 16'h1000
) (
    input  logic [OFF_W-1:0] offset,
    input  logic             size8,
    input  logic [CMD_W-1:0] data,
    output job_t             job
);
    cmd_kind_t       kind;
    logic [ID_W-1:0] id;

    always_comb begin
        kind        = classify(offset, size8);
        id          = data[ID_LSB +: ID_W];
        job.act     = (kind != K_NONE);
        job.core    = id;
        job.bad     = ({22'b0, id} >= 32'(NUM_CPU));
        job.keep    = data[KEEP_LSB +: LANES];
        job.payload = data[CMD_W-1 -: WORD_W];
        if (kind == K_MAIL)
            job.taddr = slot_addr(MBOX_BASE, data[4:2]);
        else
            job.taddr = data[TADDR_W-1:0];
    end

endmodule

// File: rtl/mbx_merge.sv
module mbx_merge
    import mbx_send_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_word,
    input  logic [LANES-1:0]  keep,
    output logic [WORD_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = keep[g] ? old_word[g*8 +: 8] : new_word[g*8 +: 8];
    end

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_send_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       act,
    input  logic       bad,
    input  logic       need_rd,
    input  logic       mem_ack,
    input  logic       mem_rvalid,
    output eng_state_t state
);
    eng_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start && act) begin
                    if (bad)          nxt = ST_DONE;
                    else if (need_rd) nxt = ST_READ;
                    else              nxt = ST_WRITE;
                end
            end
            ST_READ:    if (mem_ack)    nxt = ST_WAIT_RD;
            ST_WAIT_RD: if (mem_rvalid) nxt = ST_WRITE;
            ST_WRITE:   if (mem_ack)    nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/mbx_send_engine.sv
module mbx_send_engine
    import mbx_send_pkg::*;
#(
    parameter int                 NUM_CPU   = 4,
    parameter logic [TADDR_W-1:0] MBOX_BASE = 16'h1000,
    localparam int                CORE_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [OFF_W-1:0]   cmd_offset,
    input  logic               cmd_size8,
    input  logic [CMD_W-1:0]   cmd_data,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [TADDR_W-1:0] mem_addr,
    output logic [CORE_W-1:0]  mem_core,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               resp_valid,
    output logic               resp_err
);
    job_t              job_d;
    job_t              job_q;
    logic [WORD_W-1:0] old_q;
    eng_state_t        state;
    logic              start;

    assign start = cmd_valid && cmd_ready;

    mbx_cmd_decode #(
        .NUM_CPU   (NUM_CPU),
        .MBOX_BASE (MBOX_BASE)
    ) u_dec (
        .offset (cmd_offset),
        .size8  (cmd_size8),
        .data   (cmd_data),
        .job    (job_d)
    );

    mbx_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .act        (job_d.act),
        .bad        (job_d.bad),
        .need_rd    (job_d.keep != '0),
        .mem_ack    (mem_ack),
        .mem_rvalid (mem_rvalid),
        .state      (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q <= '0;
            old_q <= '0;
        end else begin
            if (start)
                job_q <= job_d;
            if (state == ST_WAIT_RD && mem_rvalid)
                old_q <= mem_rdata;
        end
    end

    mbx_merge u_merge (
        .old_word (old_q),
        .new_word (job_q.payload),
        .keep     (job_q.keep),
        .merged   (mem_wdata)
    );

    assign cmd_ready  = (state == ST_IDLE);
    assign busy       = (state != ST_IDLE);
    assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we     = (state == ST_WRITE);
    assign mem_addr   = job_q.taddr;
    assign mem_core   = job_q.core[CORE_W-1:0];
    assign resp_valid = (state == ST_DONE);
    assign resp_err   = (state == ST_DONE) && job_q.bad;

endmodule

// File: rtl/mbx_send_chk.sv
module mbx_send_chk #(
    parameter int NUM_CPU = 4,
    parameter int CORE_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [15:0]       mem_addr,
    input logic [CORE_W-1:0] mem_core,
    input logic              mem_ack,
    input logic              resp_valid
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cmd_ready);

    // R7
    core_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (32'(mem_core) < NUM_CPU));

    // R5
    read_gap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ack |=> !mem_req);

endmodule

bind mbx_send_engine mbx_send_chk #(
    .NUM_CPU (NUM_CPU),
    .CORE_W  (CORE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_ready  (cmd_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_core   (mem_core),
    .mem_ack    (mem_ack),
    .resp_valid (resp_valid)
);

// File: tb/test_mbx_send_engine.sv
module test_mbx_send_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [11:0] cmd_offset = '0;
    logic        cmd_size8 = 0;
    logic [63:0] cmd_data = '0;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_core;
    logic [31:0] mem_wdata;
    logic        mem_ack = 0;
    logic        mem_rvalid = 0;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid;
    logic        resp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_send_engine #(.NUM_CPU(NCPU), .MBOX_BASE(16'h1000)) i_mbx_send_engine (
        .clk, .rst, .cmd_valid, .cmd_ready, .cmd_offset, .cmd_size8, .cmd_data,
        .busy, .mem_req, .mem_we, .mem_addr, .mem_core, .mem_wdata,
        .mem_ack, .mem_rvalid, .mem_rdata, .resp_valid, .resp_err
    );

    typedef struct {
        logic        we;
        int          core;
        logic [15:0] addr;
        logic [31:0] data;
        string       tag;
    } acc_t;

    typedef struct {
        logic  err;
        string tag;
    } rsp_t;

    acc_t        exp_acc[$];
    rsp_t        exp_rsp[$];
    logic [31:0] mem [int];
    int          checks = 0;
    int          errors = 0;
    int          stall_n = 0;
    bit          done = 0;

    function automatic int key(input int core, input logic [15:0] a);
        return (core << 16) | int'(a);
    endfunction

    function automatic logic [31:0] mem_rd(input int k);
        return mem.exists(k) ? mem[k] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder and scoreboard monitor
    initial begin
        bit          rd_pend = 0;
        logic [31:0] rd_val = '0;
        int          scnt = 0;
        bit          prev_resp = 0;
        forever begin
            @(negedge clk);
            mem_ack = 0;
            mem_rvalid = 0;
            if (rd_pend) begin
                mem_rvalid = 1;
                mem_rdata  = rd_val;
                rd_pend    = 0;
            end else if (mem_req && !rst) begin
                if (scnt < stall_n) scnt++;
                else begin
                    scnt = 0;
                    mem_ack = 1;
                    if (exp_acc.size() == 0) begin
                        check(0, "R1 unexpected access", {mem_we, 15'b0, mem_addr}, 64'h0);
                    end else begin
                        acc_t e;
                        e = exp_acc.pop_front();
                        check(mem_we == e.we, {e.tag, " direction"}, 64'(mem_we), 64'(e.we));
                        check(int'(mem_core) == e.core, {e.tag, " R7 core"}, 64'(mem_core), 64'(e.core));
                        check(mem_addr == e.addr, {e.tag, " address"}, 64'(mem_addr), 64'(e.addr));
                        if (e.we)
                            check(mem_wdata == e.data, {e.tag, " write data"}, 64'(mem_wdata), 64'(e.data));
                    end
                    if (mem_we) mem[key(int'(mem_core), mem_addr)] = mem_wdata;
                    else begin
                        rd_pend = 1;
                        rd_val  = mem_rd(key(int'(mem_core), mem_addr));
                    end
                end
            end
            if (resp_valid && !rst) begin
                check(!prev_resp, "R8 response longer than one cycle", 64'(1), 64'(0));
                if (exp_rsp.size() == 0) begin
                    check(0, "R1 unexpected response", 64'(resp_err), 64'h0);
                end else begin
                    rsp_t r;
                    r = exp_rsp.pop_front();
                    check(resp_err == r.err, {r.tag, " response error flag"}, 64'(resp_err), 64'(r.err));
                end
            end
            prev_resp = resp_valid;
        end
    end

    // Driver: predicts the outcome, then issues the command
    task automatic send(input logic [11:0] off, input logic s8, input logic [63:0] d, input string tag);
        bit          proc;
        int          id;
        logic [15:0] ta;
        logic [3:0]  keep;
        logic [31:0] km;
        logic [31:0] old;
        proc = s8 && (off == 12'h048 || off == 12'h158);
        if (proc) begin
            id = int'(d[25:16]);
            if (id >= NCPU) begin
                exp_rsp.push_back('{1'b1, tag});
            end else begin
                ta   = (off == 12'h048) ? 16'h1020 + {11'b0, d[4:2], 2'b00} : d[15:0];
                keep = d[30:27];
                km   = {{8{keep[3]}}, {8{keep[2]}}, {8{keep[1]}}, {8{keep[0]}}};
                old  = mem_rd(key(id, ta));
                if (keep != 0) exp_acc.push_back('{1'b0, id, ta, 32'h0, tag});
                exp_acc.push_back('{1'b1, id, ta, (old & km) | (d[63:32] & ~km), tag});
                exp_rsp.push_back('{1'b0, tag});
            end
        end
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_offset = off; cmd_size8 = s8; cmd_data = d;
        @(negedge clk);
        cmd_valid = 0;
        if (proc) check(cmd_ready == 0, {tag, " R8 ready low while busy"}, 64'(cmd_ready), 64'h0);
        else      check(cmd_ready == 1, {tag, " R1 ignored command keeps ready"}, 64'(cmd_ready), 64'h1);
        while (!cmd_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(cmd_ready == 1, "reset R8 ready", 64'(cmd_ready), 64'h1);
        check(mem_req == 0, "reset R8 no request", 64'(mem_req), 64'h0);
        check(resp_valid == 0, "reset R8 no response", 64'(resp_valid), 64'h0);

        mem[key(2, 16'h103C)] = 32'h11223344;
        mem[key(3, 16'h0208)] = 32'hCAFEF00D;
        mem[key(0, 16'h0400)] = 32'h01020304;
        mem[key(1, 16'h1024)] = 32'h55667788;

        // R3 R6: mail, no keep, slot 3
        send(12'h048, 1, {32'hA1B2C3D4, 1'b0, 4'b0000, 11'd1, 16'h000C}, "R3/R6 mail slot3");
        // R3 R5: mail, mixed keep, slot 7
        send(12'h048, 1, {32'hAABBCCDD, 1'b0, 4'b0101, 11'd2, 16'h001C}, "R3/R5 mail mixed keep");
        // R3: stray slot bits
        send(12'h048, 1, {32'h0BADBEEF, 1'b0, 4'b0000, 11'd0, 16'hFFE3}, "R3 mail stray bits");
        // R4 R5: any, keep all
        send(12'h158, 1, {32'h99999999, 1'b0, 4'b1111, 11'd3, 16'h0208}, "R4/R5 any keep all");
        // R4 R5: any, keep top byte
        send(12'h158, 1, {32'hDEADBEEF, 1'b0, 4'b1000, 11'd0, 16'h0400}, "R4/R5 any keep top");
        // R8 R5: stalled acknowledge
        stall_n = 2;
        send(12'h048, 1, {32'h12345678, 1'b0, 4'b0010, 11'd1, 16'h0004}, "R8/R5 stalled mail");
        send(12'h158, 1, {32'h87654321, 1'b0, 4'b0000, 11'd3, 16'h7FFC}, "R8/R6 stalled any");
        stall_n = 0;
        // R2: bad core IDs
        send(12'h048, 1, {32'h11111111, 1'b0, 4'b0011, 11'd4, 16'h0000}, "R2 id just past range");
        send(12'h158, 1, {32'h22222222, 1'b0, 4'b0000, 11'h3FF, 16'h0100}, "R2 id max");
        // R1: ignored commands
        send(12'h04C, 1, {32'h33333333, 1'b0, 4'b0000, 11'd1, 16'h0000}, "R1 wrong offset");
        send(12'h048, 0, {32'h44444444, 1'b0, 4'b0000, 11'd1, 16'h0000}, "R1 short write");
        send(12'h000, 1, {32'h55555555, 1'b0, 4'b1111, 11'd0, 16'h0000}, "R1 zero offset");
        // R7: core 3 on mail after ignored traffic
        send(12'h048, 1, {32'hFEEDFACE, 1'b0, 4'b0000, 11'd3, 16'h0010}, "R7/R3 mail core3");

        repeat (5) @(negedge clk);
        check(exp_acc.size() == 0, "R5 all expected accesses seen", 64'(exp_acc.size()), 64'h0);
        check(exp_rsp.size() == 0, "R8 all expected responses seen", 64'(exp_rsp.size()), 64'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule